// File: doc/BRIEF.md
# PHY Link Status Resolver

This block polls an Ethernet PHY through the request/response side of an MDIO master and turns what it reads into the link settings a MAC needs: a link-up flag, a 100 Mb/s speed select and a full-duplex select. Each pulse on the poll input starts one sequence. The sequence reads the PHY's basic status register twice and keeps only the second value, which clears a link indication the PHY latches low. It then reads the basic control register. When auto-negotiation is enabled, it also reads the link-partner ability register.

How speed and duplex are resolved depends on the auto-negotiation enable bit. When it is set, the partner's advertised abilities decide both settings. When it is clear, the forced speed and duplex bits in the control register decide them. A poll that ends with the link down clears the link flag and leaves speed and duplex as they were. A one-cycle done pulse marks the end of every poll.

The serial MDIO engine is outside this block. The block only issues register-read requests and waits for their responses.

Top module: `phy_link_resolver`

## Requirements
- R1: After reset, link_up, speed_100, full_duplex, mdio_req_valid and poll_done are all 0 (link down, 10 Mb/s, half duplex).
- R2: A poll issues reads in this order: register 1 (status), register 1 again, register 0 (control), then register 5 (partner ability) only when control bit 12 is set. A request holds mdio_req_reg stable until mdio_req_ready. No request is raised while a response is outstanding.
- R3: The value returned by the first status read has no effect on the result. Only the second status read is used.
- R4: With control bit 12 set, the link is up only when status bit 2 (link) is 1, status bit 5 (negotiation complete) is 1 and status bit 4 (remote fault) is 0.
- R5: With control bit 12 set and the link up, speed_100 becomes 1 if any of partner bits 7, 8 or 9 (100 half, 100 full, 100BASE-T4) is set. full_duplex becomes 1 if partner bit 6 (10 full) or bit 8 (100 full) is set.
- R6: With control bit 12 clear, the link is up when status bit 2 is 1. In that case speed_100 takes control bit 13 and full_duplex takes control bit 8.
- R7: A poll that ends with the link down sets link_up to 0 and leaves speed_100 and full_duplex unchanged.
- R8: poll_done is a single-cycle pulse at the end of each poll. The new link_up, speed_100 and full_duplex values appear in that same cycle, and link_up changes at no other time.
- R9: A poll request that arrives while a sequence is in progress is ignored. It starts no extra reads and produces no extra done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| poll_req | input | 1 | Start a poll sequence (ignored while busy) |
| mdio_req_valid | output | 1 | Read request to the MDIO master |
| mdio_req_ready | input | 1 | MDIO master accepts the request |
| mdio_req_phy | output | 5 | PHY address of the request |
| mdio_req_reg | output | 5 | Register number of the request |
| mdio_rsp_valid | input | 1 | Read data valid from the MDIO master |
| mdio_rsp_data | input | 16 | Read data |
| link_up | output | 1 | Link is up |
| speed_100 | output | 1 | 1 selects 100 Mb/s, 0 selects 10 Mb/s |
| full_duplex | output | 1 | 1 selects full duplex |
| poll_done | output | 1 | One-cycle pulse at the end of a poll |

## Verification
The hardest case to reach from the ports is a latched-low link indication. The two status reads of one poll must disagree, and the result must follow the second read. The responder in the bench is scripted per poll, so the first and second status reads can return different values in both directions. The responder also varies how long it withholds ready, which holds requests under backpressure. A second poll request is injected in the middle of a sequence, and the bench confirms that the read log and the done count show only one sequence.

// File: rtl/phy_lsr_pkg.sv
package phy_lsr_pkg;

  localparam int REG_W  = 5;
  localparam int DATA_W = 16;

  // register numbers
  localparam logic [REG_W-1:0] RA_CTRL = 5'd0;
  localparam logic [REG_W-1:0] RA_STAT = 5'd1;
  localparam logic [REG_W-1:0] RA_PART = 5'd5;

  // status bits
  localparam int ST_LINK  = 2;
  localparam int ST_RFLT  = 4;
  localparam int ST_ANDON = 5;
  // control bits
  localparam int CT_DUPX  = 8;
  localparam int CT_AN    = 12;
  localparam int CT_SPD   = 13;
  // partner ability bits
  localparam int PA_10F   = 6;
  localparam int PA_100H  = 7;
  localparam int PA_100F  = 8;
  localparam int PA_T4    = 9;

  typedef enum logic [1:0] {PH_IDLE, PH_ISSUE, PH_WAIT, PH_EVAL} phase_t;
  typedef enum logic [1:0] {SP_STAT_A, SP_STAT_B, SP_CTRL, SP_PART} step_t;

  typedef struct packed {
    logic up;
    logic fast;
    logic full;
  } link_cfg_t;

  function automatic logic [REG_W-1:0] step_addr(input step_t s);
    case (s)
      SP_STAT_A, SP_STAT_B: step_addr = RA_STAT;
      SP_CTRL:              step_addr = RA_CTRL;
      default:              step_addr = RA_PART;
    endcase
  endfunction

  // Turns the captured registers into link settings.
  function automatic link_cfg_t resolve(input logic [DATA_W-1:0] st,
                                        input logic [DATA_W-1:0] ct,
                                        input logic [DATA_W-1:0] pt);
    link_cfg_t r;
    if (ct[CT_AN]) begin
      r.up   = st[ST_LINK] & st[ST_ANDON] & ~st[ST_RFLT];
      r.fast = pt[PA_100H] | pt[PA_100F] | pt[PA_T4];
      r.full = pt[PA_10F]  | pt[PA_100F];
    end else begin
      r.up   = st[ST_LINK];
      r.fast = ct[CT_SPD];
      r.full = ct[CT_DUPX];
    end
    return r;
  endfunction

endpackage

// File: rtl/phy_lsr_seq.sv
module phy_lsr_seq
  import phy_lsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             poll_req,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic             an_en_now,
  output logic             req_valid,
  output logic [REG_W-1:0] req_reg,
  output logic             cap_stat,
  output logic             cap_ctrl,
  output logic             cap_part,
  output logic             eval,
  output logic             waiting
);

  phase_t phase_q;
  step_t  step_q;
  logic   rsp_hit;

  always_comb begin
    req_valid = (phase_q == PH_ISSUE);
    req_reg   = step_addr(step_q);
    waiting   = (phase_q == PH_WAIT);
    rsp_hit   = waiting && rsp_valid;
    // first status read is deliberately not captured
    cap_stat  = rsp_hit && (step_q == SP_STAT_B);
    cap_ctrl  = rsp_hit && (step_q == SP_CTRL);
    cap_part  = rsp_hit && (step_q == SP_PART);
    eval      = (phase_q == PH_EVAL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      step_q  <= SP_STAT_A;
    end else begin
      case (phase_q)
        PH_IDLE: if (poll_req) begin
          phase_q <= PH_ISSUE;
          step_q  <= SP_STAT_A;
        end
        PH_ISSUE: if (req_ready) phase_q <= PH_WAIT;
        PH_WAIT: if (rsp_valid) begin
          case (step_q)
            SP_STAT_A: begin step_q <= SP_STAT_B; phase_q <= PH_ISSUE; end
            SP_STAT_B: begin step_q <= SP_CTRL;   phase_q <= PH_ISSUE; end
            SP_CTRL: begin
              if (an_en_now) begin
                step_q  <= SP_PART;
                phase_q <= PH_ISSUE;
              end else begin
                phase_q <= PH_EVAL;
              end
            end
            default: phase_q <= PH_EVAL;
          endcase
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/phy_lsr_capture.sv
module phy_lsr_capture
  import phy_lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_stat,
  input  logic              cap_ctrl,
  input  logic              cap_part,
  input  logic [DATA_W-1:0] rsp_data,
  output logic [DATA_W-1:0] stat_q,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] part_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= '0;
      ctrl_q <= '0;
      part_q <= '0;
    end else begin
      if (cap_stat) stat_q <= rsp_data;
      if (cap_ctrl) ctrl_q <= rsp_data;
      if (cap_part) part_q <= rsp_data;
    end
  end

endmodule

// File: rtl/phy_lsr_apply.sv
module phy_lsr_apply
  import phy_lsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval,
  input  logic [DATA_W-1:0] stat_q,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [DATA_W-1:0] part_q,
  output logic              link_up,
  output logic              speed_100,
  output logic              full_duplex,
  output logic              done
);

  link_cfg_t cfg;

  always_comb cfg = resolve(stat_q, ctrl_q, part_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_up     <= 1'b0;
      speed_100   <= 1'b0;
      full_duplex <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= eval;
      if (eval) begin
        link_up <= cfg.up;
        if (cfg.up) begin
          speed_100   <= cfg.fast;
          full_duplex <= cfg.full;
        end
      end
    end
  end

endmodule

// File: rtl/phy_link_resolver.sv
module phy_link_resolver
  import phy_lsr_pkg::*;
#(
  parameter logic [4:0] PHY_ADDR = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        poll_req,
  output logic        mdio_req_valid,
  input  logic        mdio_req_ready,
  output logic [4:0]  mdio_req_phy,
  output logic [4:0]  mdio_req_reg,
  input  logic        mdio_rsp_valid,
  input  logic [15:0] mdio_rsp_data,
  output logic        link_up,
  output logic        speed_100,
  output logic        full_duplex,
  output logic        poll_done
);

  logic              cap_stat_evt, cap_ctrl_evt, cap_part_evt;
  logic              eval_evt, seq_waiting;
  logic [DATA_W-1:0] stat_q, ctrl_q, part_q;

  assign mdio_req_phy = PHY_ADDR;

  phy_lsr_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .poll_req  (poll_req),
    .req_ready (mdio_req_ready),
    .rsp_valid (mdio_rsp_valid),
    .an_en_now (mdio_rsp_data[CT_AN]),
    .req_valid (mdio_req_valid),
    .req_reg   (mdio_req_reg),
    .cap_stat  (cap_stat_evt),
    .cap_ctrl  (cap_ctrl_evt),
    .cap_part  (cap_part_evt),
    .eval      (eval_evt),
    .waiting   (seq_waiting)
  );

  phy_lsr_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_stat (cap_stat_evt),
    .cap_ctrl (cap_ctrl_evt),
    .cap_part (cap_part_evt),
    .rsp_data (mdio_rsp_data),
    .stat_q   (stat_q),
    .ctrl_q   (ctrl_q),
    .part_q   (part_q)
  );

  phy_lsr_apply u_apply (
    .clk         (clk),
    .rst_n       (rst_n),
    .eval        (eval_evt),
    .stat_q      (stat_q),
    .ctrl_q      (ctrl_q),
    .part_q      (part_q),
    .link_up     (link_up),
    .speed_100   (speed_100),
    .full_duplex (full_duplex),
    .done        (poll_done)
  );

endmodule

// File: rtl/phy_lsr_checker.sv
module phy_lsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic [4:0] req_reg,
  input logic       waiting,
  input logic       done,
  input logic       link_up,
  input logic       fast,
  input logic       full
);

  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_reg)));

  p_no_req_in_wait_r2: assert property (@(posedge clk) disable iff (!rst_n)
    waiting |-> !req_valid);

  p_reg_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_reg == 5'd0 || req_reg == 5'd1 || req_reg == 5'd5));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_link_chg_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up != $past(link_up)) |-> done);

  p_cfg_chg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((fast != $past(fast)) || (full != $past(full))) |-> (done && link_up));

endmodule

bind phy_link_resolver phy_lsr_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (mdio_req_valid),
  .req_ready (mdio_req_ready),
  .req_reg   (mdio_req_reg),
  .waiting   (seq_waiting),
  .done      (poll_done),
  .link_up   (link_up),
  .fast      (speed_100),
  .full      (full_duplex)
);

// File: tb/phy_link_resolver_bench.sv
module phy_link_resolver_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        poll_req = 1'b0;
  logic        mdio_req_valid, mdio_req_ready = 1'b0;
  logic [4:0]  mdio_req_phy, mdio_req_reg;
  logic        mdio_rsp_valid = 1'b0;
  logic [15:0] mdio_rsp_data = '0;
  logic        link_up, speed_100, full_duplex, poll_done;

  always #5 clk = ~clk;

  phy_link_resolver u_phy_link_resolver (
    .clk(clk), .rst_n(rst_n), .poll_req(poll_req),
    .mdio_req_valid(mdio_req_valid), .mdio_req_ready(mdio_req_ready),
    .mdio_req_phy(mdio_req_phy), .mdio_req_reg(mdio_req_reg),
    .mdio_rsp_valid(mdio_rsp_valid), .mdio_rsp_data(mdio_rsp_data),
    .link_up(link_up), .speed_100(speed_100), .full_duplex(full_duplex),
    .poll_done(poll_done)
  );

  int checks = 0;
  int fails  = 0;
  string cur_tag = "R1";

  // PHY model contents for the current poll
  logic [15:0] m_stat1, m_stat2, m_ctrl, m_part;
  int          stat_seen;
  int          lat_sel = 0;
  logic [4:0]  log_regs[$];

  // scoreboard: {up, fast, full}
  logic [2:0]  exp_q[$];
  logic        e_fast = 1'b0, e_full = 1'b0;

  // responder
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && mdio_req_valid) begin
        logic [4:0] ra;
        repeat (lat_sel) @(negedge clk);
        lat_sel = (lat_sel + 1) % 3;
        ra = mdio_req_reg;
        log_regs.push_back(ra);
        mdio_req_ready = 1'b1;
        @(negedge clk);
        mdio_req_ready = 1'b0;
        repeat (2) @(negedge clk);
        if (ra == 5'd1) begin
          mdio_rsp_data = (stat_seen == 0) ? m_stat1 : m_stat2;
          stat_seen++;
        end else if (ra == 5'd0) mdio_rsp_data = m_ctrl;
        else if (ra == 5'd5)     mdio_rsp_data = m_part;
        else                     mdio_rsp_data = 16'hDEAD;
        mdio_rsp_valid = 1'b1;
        @(negedge clk);
        mdio_rsp_valid = 1'b0;
        mdio_rsp_data  = 16'h0000;
      end
    end
  end

  // monitor
  always @(negedge clk) begin
    if (rst_n && poll_done) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL [%s] unexpected done pulse: actual=done expected=none", cur_tag);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        if ({link_up, speed_100, full_duplex} !== e) begin
          fails++;
          $display("FAIL [%s] {link,speed,duplex}: actual=%b expected=%b",
                   cur_tag, {link_up, speed_100, full_duplex}, e);
        end
      end
    end
  end

  task automatic check(input string tag, input logic ok, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL [%s] actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic logic [2:0] predict(input logic [15:0] s, input logic [15:0] c,
                                         input logic [15:0] p);
    logic up;
    if (c[12]) up = (s & 16'h0034) == 16'h0024;
    else       up = s[2];
    if (up) begin
      if (c[12]) begin
        e_fast = (p & 16'h0380) != 0;
        e_full = (p & 16'h0140) != 0;
      end else begin
        e_fast = c[13];
        e_full = c[8];
      end
    end
    return {up, e_fast, e_full};
  endfunction

  task automatic settle();
    int n = 0;
    while ((exp_q.size() != 0) && (n < 300)) begin @(negedge clk); n++; end
    repeat (6) @(negedge clk);
  endtask

  task automatic do_poll(input logic [15:0] s1, input logic [15:0] s2,
                         input logic [15:0] c, input logic [15:0] p,
                         input string tag, input logic busy_req);
    int nexp;
    cur_tag   = tag;
    m_stat1   = s1; m_stat2 = s2; m_ctrl = c; m_part = p;
    stat_seen = 0;
    log_regs.delete();
    exp_q.push_back(predict(s2, c, p));
    @(negedge clk); poll_req = 1'b1;
    @(negedge clk); poll_req = 1'b0;
    if (busy_req) begin
      repeat (4) @(negedge clk); poll_req = 1'b1;
      @(negedge clk); poll_req = 1'b0;
      repeat (5) @(negedge clk); poll_req = 1'b1;
      @(negedge clk); poll_req = 1'b0;
    end
    settle();
    // read order check (R2)
    nexp = c[12] ? 4 : 3;
    check({tag, " R2 read count"}, log_regs.size() == nexp, log_regs.size(), nexp);
    if (log_regs.size() == nexp) begin
      check({tag, " R2 order"},
            log_regs[0] == 5'd1 && log_regs[1] == 5'd1 && log_regs[2] == 5'd0 &&
            (nexp == 3 || log_regs[3] == 5'd5), log_regs[2], 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check("R1 link", link_up === 1'b0, link_up, 0);
    check("R1 speed", speed_100 === 1'b0, speed_100, 0);
    check("R1 duplex", full_duplex === 1'b0, full_duplex, 0);
    check("R1 req", mdio_req_valid === 1'b0, mdio_req_valid, 0);
    check("R1 done", poll_done === 1'b0, poll_done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R3 latched-low first read, R4/R5 good link with 100 full partner
    do_poll(16'h0020, 16'h0024, 16'h1000, 16'h0100, "R3 R5 100full", 1'b0);
    do_poll(16'h0024, 16'h0024, 16'h1000, 16'h0040, "R5 10full", 1'b0);
    do_poll(16'h0024, 16'h0024, 16'h1000, 16'h0080, "R5 100half", 1'b0);
    do_poll(16'h0024, 16'h0024, 16'h1000, 16'h0200, "R5 t4", 1'b0);
    // R4 / R7 fault and incomplete negotiation
    do_poll(16'h0024, 16'h0034, 16'h1000, 16'h0040, "R4 R7 fault", 1'b0);
    do_poll(16'h0024, 16'h0004, 16'h1000, 16'h0140, "R4 R7 no-anc", 1'b0);
    do_poll(16'h0024, 16'h0024, 16'h1000, 16'h0020, "R5 10half", 1'b0);
    // R6 forced mode
    do_poll(16'h0000, 16'h0004, 16'h2000, 16'hFFFF, "R6 100 half", 1'b0);
    do_poll(16'h0004, 16'h0000, 16'h0100, 16'hFFFF, "R3 R7 forced down", 1'b0);
    do_poll(16'h0000, 16'h0004, 16'h0100, 16'h0000, "R6 10 full", 1'b0);
    // R9 requests during an active sequence
    do_poll(16'h0024, 16'h0024, 16'h1000, 16'h0180, "R9 busy", 1'b1);
    repeat (40) @(negedge clk);
    check("R9 no extra reads", log_regs.size() == 4, log_regs.size(), 4);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL [%s] watchdog: actual=hung expected=complete", cur_tag);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule